// File: doc/BRIEF.md
# Flag-Driven FIFO Burst Write Master

This block pushes 32-bit words from a local valid/ready stream into the slave FIFO of an external bridge device. The bridge returns two status flags. One is a space flag, high while the current buffer can take data. The other is a low-space flag, which rises once the free space falls to the programmed watermark. Both flags report the result of a write only several clocks after that write. The master therefore keeps its own count of the words it has written into the current buffer and does not read a still-high flag as proof that space exists.

While the buffer is far from full, the block writes on every clock that the stream offers a word. Near the end of a buffer it switches to paced operation. This mode starts when the low-space flag is active or when its own count reaches the watermark distance from the end. In paced operation it writes one word and then stays quiet for a fixed recheck interval, so that the space flag has caught up before it is sampled again. When the space flag drops, the block stalls and keeps the pending word upstream. It waits for the flag to return high, which marks a fresh buffer, then clears its count and goes back to bursting.

Top module: `fifo_burst_writer`

## Requirements
- R1: While `rst_n` is low, `wr_n` is high and `s_ready` is low, and `wr_n` is still high on the first cycle after reset is released.
- R2: With the space flag high, the low-space flag low and fewer than BUF_WORDS-WMARK words written into the current buffer, a word offered on every clock is accepted on every clock, and the resulting writes appear on consecutive cycles.
- R3: Words reach `wr_data` in the order they were accepted, with none lost and none duplicated.
- R4: Once the count for the buffer has reached BUF_WORDS-WMARK (4 words from the end by default), or the low-space flag is high, two writes are at least RECHECK+1 = 5 cycles apart. The master samples the space flag again only after the 4-cycle recheck wait.
- R5: No more than BUF_WORDS (1024) words are written into one buffer, so no write ever hits a full buffer.
- R6: A clock on which the space flag is low never launches a write: `wr_n` is high on the following cycle.
- R7: After the space flag has been seen low, `s_ready` stays low until the flag is high again. The count is then cleared and full-rate writing resumes in the new buffer.
- R8: A word is consumed only on a clock where `s_valid` and `s_ready` are both high. `wr_n` (active low) goes low on exactly the cycle after each such clock, with that word on `wr_data`.
- R9: A clock without `s_valid` never launches a write: `wr_n` is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Stream word present |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Block accepts the stream word this clock |
| flag_space | input | 1 | Bridge buffer can take data (high = space), lags writes |
| flag_low | input | 1 | Remaining space at or below watermark (high = low), lags writes |
| wr_n | output | 1 | Write strobe to bridge, active low |
| wr_data | output | 32 | Data to bridge, valid while `wr_n` is low |

## Verification
A write is due one cycle after the clock on which `s_valid` and `s_ready` were both high. The bench therefore records every handshake it sees at a falling edge and expects the strobe at the next falling edge. The bridge model captures each strobed word at the falling edge and passes both flags through three register stages. A flag change is thus visible three clocks after the write, and near the watermark the bench expects gaps of at least five cycles between writes. The flag and valid values that decide whether a write may be launched are kept from the previous falling edge. Each strobe is compared against those values and not against the current ones.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [1:0] {
    MODE_BURST = 2'd0,
    MODE_PACED = 2'd1,
    MODE_STALL = 2'd2
  } wmode_e;

  // True when writes must be paced: flag already warns, or own count is close to the end.
  function automatic logic near_limit(input int unsigned cnt,
                                      input int unsigned buf_words,
                                      input int unsigned wmark,
                                      input logic        low_flag);
    return low_flag || ((cnt + wmark) >= buf_words);
  endfunction

  // True while the own count still leaves at least one free word.
  function automatic logic has_room(input int unsigned cnt,
                                    input int unsigned buf_words);
    return cnt < buf_words;
  endfunction

endpackage

// File: rtl/fbw_space_tracker.sv
module fbw_space_tracker #(
  parameter int unsigned BUF_WORDS = 1024,
  parameter int unsigned WMARK     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic flag_space_i,
  input  logic flag_low_i,
  output logic stall_o,
  output logic near_o,
  output logic room_o
);
  import fbw_pkg::*;

  localparam int CNT_W = $clog2(BUF_WORDS + 1);

  logic [CNT_W-1:0] count_q;
  logic             stall_q;
  logic             buf_switch_w;

  // Fresh buffer seen: stalled and the space flag is back.
  assign buf_switch_w = stall_q && flag_space_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      stall_q <= 1'b0;
    end else if (buf_switch_w) begin
      count_q <= '0;
      stall_q <= 1'b0;
    end else if (!stall_q && !flag_space_i) begin
      stall_q <= 1'b1;
    end else if (fire_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign stall_o = stall_q;
  assign near_o  = near_limit(int'(count_q), BUF_WORDS, WMARK, flag_low_i);
  assign room_o  = has_room(int'(count_q), BUF_WORDS);

  // R5: a write is never launched with the buffer already counted full
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> (int'(count_q) < BUF_WORDS));

  // R7: a stall persists while the space flag stays low
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !flag_space_i) |=> stall_q);

  // R7: leaving a stall starts a new buffer from zero
  a_r7_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    buf_switch_w |=> (count_q == '0 && !stall_q));

endmodule

// File: rtl/fbw_pace_timer.sv
module fbw_pace_timer #(
  parameter int unsigned RECHECK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic near_i,
  output logic quiet_o
);
  localparam int W = $clog2(RECHECK + 1);
  localparam logic [W-1:0] LOAD = W'(RECHECK);

  logic [W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             wait_q <= '0;
    else if (fire_i)        wait_q <= LOAD;
    else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
  end

  assign quiet_o = (wait_q == '0);

  // R4: every write opens a recheck window
  a_r4_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> !quiet_o);

  // R4: in paced mode no write follows directly on another
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && near_i) |=> !fire_i);

endmodule

// File: rtl/fbw_write_port.sv
module fbw_write_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          valid_i,
  input  logic          flag_space_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_n_o,
  output logic [DW-1:0] wr_data_o
);
  logic          wr_n_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      data_q <= '0;
    end else begin
      wr_n_q <= !fire_i;
      if (fire_i) data_q <= data_i;
    end
  end

  assign wr_n_o    = wr_n_q;
  assign wr_data_o = data_q;

  // R1: strobe idle on the first cycle out of reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> wr_n_q);

  // R8: each handshake becomes a strobe carrying that word one cycle later
  a_r8_launch: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (!wr_n_q && data_q == $past(data_i)));

  // R9: no stream word, no strobe
  a_r9_no_valid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> wr_n_q);

  // R6: a low space flag never launches a write
  a_r6_no_space_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_space_i |=> wr_n_q);

endmodule

// File: rtl/fifo_burst_writer.sv
module fifo_burst_writer #(
  parameter int unsigned DW        = 32,
  parameter int unsigned BUF_WORDS = 1024,
  parameter int unsigned WMARK     = 4,
  parameter int unsigned RECHECK   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  input  logic          flag_space,
  input  logic          flag_low,
  output logic          wr_n,
  output logic [DW-1:0] wr_data
);
  import fbw_pkg::*;

  logic   stall_w;
  logic   near_w;
  logic   room_w;
  logic   quiet_w;
  logic   fire_w;
  wmode_e mode_w;

  fbw_space_tracker #(.BUF_WORDS(BUF_WORDS), .WMARK(WMARK)) u_space (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire_w),
    .flag_space_i (flag_space),
    .flag_low_i   (flag_low),
    .stall_o      (stall_w),
    .near_o       (near_w),
    .room_o       (room_w)
  );

  fbw_pace_timer #(.RECHECK(RECHECK)) u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire_w),
    .near_i  (near_w),
    .quiet_o (quiet_w)
  );

  always_comb begin
    if (stall_w)     mode_w = MODE_STALL;
    else if (near_w) mode_w = MODE_PACED;
    else             mode_w = MODE_BURST;
  end

  assign s_ready = rst_n && !stall_w && flag_space && room_w && (!near_w || quiet_w);
  assign fire_w  = s_valid && s_ready;

  fbw_write_port #(.DW(DW)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire_w),
    .valid_i      (s_valid),
    .flag_space_i (flag_space),
    .data_i       (s_data),
    .wr_n_o       (wr_n),
    .wr_data_o    (wr_data)
  );

  // R7: stalled mode accepts nothing
  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_STALL) |-> !s_ready);

  // R2: in burst mode with space and a word, the word is taken
  a_r2_burst_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_BURST && flag_space && s_valid) |-> fire_w);

endmodule

// File: tb/fifo_burst_writer_bench.sv
`timescale 1ns/1ps
module fifo_burst_writer_bench;
  localparam int unsigned BUF   = 1024;
  localparam int unsigned WM    = 4;
  localparam int unsigned GAPMIN = 5;
  localparam int unsigned N_A   = 300;
  localparam int unsigned N_ALL = 2200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        flag_space;
  logic        flag_low;
  logic        wr_n;
  logic [31:0] wr_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  fifo_burst_writer u_fifo_burst_writer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .flag_space(flag_space), .flag_low(flag_low), .wr_n(wr_n), .wr_data(wr_data)
  );

  // bridge model state
  int   fill = 0;
  int   full_cnt = 0;
  int   buffers = 0;
  int   wcount = 0;
  logic [1:0] p1 = 2'b10, p2 = 2'b10, p3 = 2'b10;   // {space, low}
  assign flag_space = p3[1];
  assign flag_low   = p3[0];

  always @(posedge clk) begin
    p1 <= {(fill < int'(BUF)), ((int'(BUF) - fill) <= int'(WM))};
    p2 <= p1;
    p3 <= p2;
  end

  logic [31:0] exp_q[$];
  int   cyc = 0;
  int   last_wr = -100;
  logic prev_space = 1'b1, prev_valid = 1'b0, prev_fire = 1'b0;
  bit   phase_a = 1'b1;
  int   received = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and bridge capture, away from the rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(wr_n === 1'b1 && s_ready === 1'b0, "R1 idle in reset", {wr_n, s_ready}, 2'b10);
    end else begin
      cyc++;
      chk((!wr_n) == prev_fire, "R8 strobe follows handshake", !wr_n, prev_fire);
      if (!wr_n) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected word", wr_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(wr_data == e, "R3 data order", wr_data, e);
        end
        chk(fill < int'(BUF), "R5 write into full buffer", fill, BUF - 1);
        chk(prev_space, "R6 write after low space flag", prev_space, 1);
        chk(prev_valid, "R9 write without valid", prev_valid, 1);
        if (wcount >= int'(BUF - WM))
          chk(cyc - last_wr >= int'(GAPMIN), "R4 paced gap", cyc - last_wr, GAPMIN);
        if (phase_a && wcount > 0)
          chk(cyc - last_wr == 1, "R2 burst gap", cyc - last_wr, 1);
        last_wr = cyc;
        fill++;
        wcount++;
        received++;
      end
      if (fill == int'(BUF)) begin
        chk(!s_ready, "R7 ready while buffer full", s_ready, 0);
        full_cnt++;
        if (full_cnt == 12) begin
          fill = 0; full_cnt = 0; buffers++; wcount = 0;
        end
      end
      prev_space = flag_space;
      prev_valid = s_valid;
      prev_fire  = s_valid && s_ready;
    end
  end

  task automatic send(input logic [31:0] w);
    bit ok;
    ok = 0;
    while (!ok) begin
      @(posedge clk); #1;
      s_valid = 1'b1; s_data = w;
      @(negedge clk); #0.1;
      ok = s_ready;
    end
    exp_q.push_back(w);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      s_valid = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(wr_n === 1'b1, "R1 idle after reset", wr_n, 1);
        // R2: back-to-back phase far from the watermark
        for (int i = 0; i < int'(N_A); i++) send(32'hC0DE0000 + i);
        idle(1);
        @(negedge clk); phase_a = 0;
        // R4/R5/R7: irregular traffic over two buffer switches
        for (int i = int'(N_A); i < int'(N_ALL); i++) begin
          send(32'hC0DE0000 + i);
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (lf[2]) idle(int'(lf[1:0]));
        end
        idle(40);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    chk(exp_q.size() == 0, "R3 words left unwritten", exp_q.size(), 0);
    chk(received == int'(N_ALL), "R3 total written", received, N_ALL);
    chk(buffers == 2, "R7 buffers completed", buffers, 2);
    chk(fill == int'(N_ALL - 2 * BUF), "R7 resumed fill", fill, N_ALL - 2 * BUF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule